// File: doc/BRIEF.md
# Dual-Channel Pulse Waveform Sequencer

The sequencer paces a two-polarization radar transmitter, one pulse at a time. While `run` is high it emits a one-cycle trigger at intervals counted in system clock cycles. The spacing follows one of three modes: uniform, alternating between two intervals, or runs of equal length at each of two intervals in turn. With every trigger it presents, for that pulse, a running pulse number, which of the horizontal and vertical channels should radiate, a separate inter-pulse phase word for each channel, and a waveform-select code for the intra-pulse modulator. It also steps an address into a downstream amplitude-shaping table for the length of the pulse.

Software programs the block through a single-cycle write port. All settings are held in configuration registers. They are sampled only at the cycle in which a pulse starts, so a change never disturbs the interval or the envelope already in progress. When `run` falls, every pulse-by-pulse pointer returns to its start point, so the next burst repeats the programmed sequences from their first entries.

Register map (8-bit address, 16-bit data): 0x00 interval A; 0x01 interval B; 0x02 control (bits 1:0 spacing mode with 0 = uniform, 1 = alternating, 2 = runs; bit 2 shaped envelope; bits 4:3 waveform code); 0x03 run length; 0x04 polarization pattern (bits 7:0 hold four 2-bit slots, slot s at bits 2s+1:2s, with bit 0 of a slot enabling H and bit 1 enabling V; bits 9:8 hold the index of the last slot used); 0x05 index of the last phase-table entry used; 0x06 envelope length in cycles; 0x40 to 0x7F the H phase table; 0x80 to 0xBF the V phase table.

Top module: `dual_pol_pulse_seq`

## Requirements
- R1: The first trigger appears exactly one clock after `run` is first sampled high. `pulse_idx` is 0 on that trigger and rises by one on each later trigger. Dropping `run` restarts the pulse number, the polarization slot and the phase pointer from zero.
- R2: In uniform mode (mode 0), consecutive triggers are exactly interval A cycles apart.
- R3: In alternating mode (mode 1), pulse k is followed by interval A when k is even and by interval B when k is odd.
- R4: In run mode (mode 2) with run length L, pulse k is followed by interval A when floor(k/L) is even and by interval B otherwise.
- R5: A new interval written during a pulse leaves the current interval unchanged and takes effect from the next pulse start.
- R6: On pulse k, `tx_h` equals bit 0 and `tx_v` equals bit 1 of pattern slot k mod (last slot index + 1).
- R7: On pulse k, `phase_h` and `phase_v` are the 12-bit entries at index k mod (last phase index + 1) of the H and V tables respectively. The two tables are independent.
- R8: Both phase words stay constant between triggers.
- R9: For an envelope length W, `env_valid` is high for W cycles starting with the trigger cycle. In shaped mode `env_addr` counts 0 to W-1 during that time. In rectangular mode it stays 0.
- R10: `wave_sel` on each trigger equals the waveform code (control bits 4:3) programmed at that pulse's start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to sequence pulses; low parks and rewinds the sequence |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register or table address |
| cfg_wdata | input | 16 | Configuration write data |
| trig | output | 1 | One-cycle transmit trigger |
| pulse_idx | output | 16 | Number of the current pulse since `run` rose |
| tx_h | output | 1 | Horizontal channel radiates on this pulse |
| tx_v | output | 1 | Vertical channel radiates on this pulse |
| phase_h | output | 12 | Inter-pulse phase word, horizontal channel |
| phase_v | output | 12 | Inter-pulse phase word, vertical channel |
| wave_sel | output | 2 | Intra-pulse waveform code for this pulse |
| env_addr | output | 8 | Address into the amplitude-shaping table |
| env_valid | output | 1 | Envelope address is active |

## Verification
The embedded properties take for granted that both intervals are at least two cycles whenever `run` is high. Only then are triggers never back to back and the tick-down check meaningful. They also assume a run length of at least one and an envelope shorter than the shorter interval, so one envelope ends before the next pulse starts. The stimulus sweeps every spacing mode over interval pairs from 2 to 7 cycles, run lengths 1 to 3, all four pattern lengths and several phase sequence lengths, including the full 64-entry table. In every case the envelope length is set to one less than the smaller interval, and settings are written only while `run` is low. The single exception is the mid-burst interval change, which is timed well clear of a pulse start.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [1:0] {
      PRT_UNIFORM = 2'd0,
      PRT_STAGGER = 2'd1,
      PRT_BLOCK   = 2'd2
   } prt_mode_e;

   localparam int CFG_AW = 8;

   localparam logic [CFG_AW-1:0] REG_PRT_A   = 8'h00;
   localparam logic [CFG_AW-1:0] REG_PRT_B   = 8'h01;
   localparam logic [CFG_AW-1:0] REG_CTRL    = 8'h02;
   localparam logic [CFG_AW-1:0] REG_BLK_LEN = 8'h03;
   localparam logic [CFG_AW-1:0] REG_POL     = 8'h04;
   localparam logic [CFG_AW-1:0] REG_PH_LAST = 8'h05;
   localparam logic [CFG_AW-1:0] REG_ENV_LEN = 8'h06;

   localparam logic [1:0] PAGE_TAB_H = 2'b01;
   localparam logic [1:0] PAGE_TAB_V = 2'b10;

endpackage

// File: rtl/dps_prt_timer.sv
module dps_prt_timer
   import dps_pkg::*;
#(
   parameter int PRT_W    = 16,
   parameter int BLK_W    = 8,
   parameter bit BLOCK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRT_W-1:0] prt_a,
   input  logic [PRT_W-1:0] prt_b,
   input  prt_mode_e        mode,
   input  logic [BLK_W-1:0] blk_len,
   output logic             go
);

   generate
      if (PRT_W < 2) begin : g_bad_prt_w
         $error("dps_prt_timer: PRT_W must be at least 2");
      end
   endgenerate

   logic [PRT_W-1:0] cnt_q;
   logic             alt_q;
   logic             blk_b;
   logic             use_b;
   logic [PRT_W-1:0] sel_prt;

   assign go = run && (cnt_q == '0);

   generate
      if (BLOCK_EN) begin : g_blk
         logic [BLK_W-1:0] bcnt_q;
         logic             bsel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bcnt_q <= '0;
               bsel_q <= 1'b0;
            end else if (!run) begin
               bcnt_q <= '0;
               bsel_q <= 1'b0;
            end else if (go) begin
               if (bcnt_q == blk_len - 1'b1) begin
                  bcnt_q <= '0;
                  bsel_q <= ~bsel_q;
               end else begin
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
         end
         assign blk_b = bsel_q;
      end else begin : g_no_blk
         logic unused_len;
         assign unused_len = ^blk_len;
         assign blk_b = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mode)
         PRT_STAGGER: use_b = alt_q;
         PRT_BLOCK:   use_b = blk_b;
         default:     use_b = 1'b0;
      endcase
      sel_prt = use_b ? prt_b : prt_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         alt_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         alt_q <= 1'b0;
      end else if (go) begin
         cnt_q <= sel_prt - 1'b1;
         alt_q <= ~alt_q;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R2
   tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !go |=> !run || (cnt_q == $past(cnt_q) - 1'b1));

   // R3
   stagger_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && go |=> !run || (alt_q != $past(alt_q)));

endmodule

// File: rtl/dps_phase_table.sv
module dps_phase_table #(
   parameter int PHASE_W = 12,
   parameter int DEPTH   = 64,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [PHASE_W-1:0] wdata,
   input  logic               rd_en,
   input  logic [AW-1:0]      raddr,
   output logic [PHASE_W-1:0] phase
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("dps_phase_table: DEPTH must be a power of two");
      end
   endgenerate

   logic [PHASE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (rd_en) begin
         phase <= mem[raddr];
      end
   end

   // R8
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(phase));

endmodule

// File: rtl/dps_envelope.sv
module dps_envelope #(
   parameter int ENV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic [ENV_W-1:0] width,
   input  logic             shaped,
   output logic [ENV_W-1:0] env_addr,
   output logic             env_valid
);

   logic [ENV_W-1:0] left_q;
   logic             shaped_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_addr  <= '0;
         env_valid <= 1'b0;
         left_q    <= '0;
         shaped_q  <= 1'b0;
      end else if (!run) begin
         env_addr  <= '0;
         env_valid <= 1'b0;
         left_q    <= '0;
      end else if (start) begin
         env_addr  <= '0;
         env_valid <= (width != '0);
         left_q    <= width - 1'b1;
         shaped_q  <= shaped;
      end else if (env_valid) begin
         if (left_q == '0) begin
            env_valid <= 1'b0;
         end else begin
            left_q   <= left_q - 1'b1;
            env_addr <= env_addr + {{(ENV_W-1){1'b0}}, shaped_q};
         end
      end
   end

   // R9
   env_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(env_valid) |-> env_addr == '0);

   // R9
   env_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      env_valid && !shaped_q && !$rose(env_valid) |-> $stable(env_addr));

endmodule

// File: rtl/dual_pol_pulse_seq.sv
module dual_pol_pulse_seq
   import dps_pkg::*;
#(
   parameter int PRT_W    = 16,
   parameter int BLK_W    = 8,
   parameter int IDX_W    = 16,
   parameter int PHASE_W  = 12,
   parameter int PH_DEPTH = 64,
   parameter int ENV_W    = 8,
   parameter int CFG_DW   = 16,
   parameter logic [PRT_W-1:0] PRT_RESET = 16,
   parameter bit BLOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic              trig,
   output logic [IDX_W-1:0]  pulse_idx,
   output logic              tx_h,
   output logic              tx_v,
   output logic [PHASE_W-1:0] phase_h,
   output logic [PHASE_W-1:0] phase_v,
   output logic [1:0]        wave_sel,
   output logic [ENV_W-1:0]  env_addr,
   output logic              env_valid
);

   localparam int PH_AW = $clog2(PH_DEPTH);
   localparam int NCH   = 2;

   generate
      if (PHASE_W < 11) begin : g_bad_res
         $error("dual_pol_pulse_seq: PHASE_W below 11 cannot reach 0.2 degree steps");
      end
      if (CFG_DW < PRT_W || CFG_DW < PHASE_W || CFG_DW < 10 || CFG_DW < ENV_W || CFG_DW < BLK_W) begin : g_bad_dw
         $error("dual_pol_pulse_seq: CFG_DW too narrow for a register field");
      end
      if (PH_AW > CFG_AW - 2) begin : g_bad_depth
         $error("dual_pol_pulse_seq: PH_DEPTH exceeds the table page");
      end
   endgenerate

   // configuration registers
   logic [PRT_W-1:0]   prt_a_q, prt_b_q;
   prt_mode_e          mode_q;
   logic               shaped_q;
   logic [1:0]         wave_cfg_q;
   logic [BLK_W-1:0]   blk_len_q;
   logic [7:0]         pol_pat_q;
   logic [1:0]         pol_last_q;
   logic [PH_AW-1:0]   ph_last_q;
   logic [ENV_W-1:0]   env_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prt_a_q    <= PRT_RESET;
         prt_b_q    <= PRT_RESET;
         mode_q     <= PRT_UNIFORM;
         shaped_q   <= 1'b0;
         wave_cfg_q <= 2'd0;
         blk_len_q  <= BLK_W'(1);
         pol_pat_q  <= 8'b00_11_01_10;
         pol_last_q <= 2'd0;
         ph_last_q  <= '0;
         env_len_q  <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_PRT_A:   prt_a_q    <= cfg_wdata[PRT_W-1:0];
            REG_PRT_B:   prt_b_q    <= cfg_wdata[PRT_W-1:0];
            REG_CTRL: begin
               mode_q     <= prt_mode_e'(cfg_wdata[1:0]);
               shaped_q   <= cfg_wdata[2];
               wave_cfg_q <= cfg_wdata[4:3];
            end
            REG_BLK_LEN: blk_len_q  <= cfg_wdata[BLK_W-1:0];
            REG_POL: begin
               pol_pat_q  <= cfg_wdata[7:0];
               pol_last_q <= cfg_wdata[9:8];
            end
            REG_PH_LAST: ph_last_q  <= cfg_wdata[PH_AW-1:0];
            REG_ENV_LEN: env_len_q  <= cfg_wdata[ENV_W-1:0];
            default: ;
         endcase
      end
   end

   // pulse boundary
   logic go;

   dps_prt_timer #(
      .PRT_W    (PRT_W),
      .BLK_W    (BLK_W),
      .BLOCK_EN (BLOCK_EN)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .prt_a   (prt_a_q),
      .prt_b   (prt_b_q),
      .mode    (mode_q),
      .blk_len (blk_len_q),
      .go      (go)
   );

   // per-pulse sequencing
   logic [IDX_W-1:0] idx_q;
   logic [1:0]       slot_q;
   logic [PH_AW-1:0] ptr_q;
   logic [1:0]       slot_code;

   assign slot_code = pol_pat_q[2*slot_q +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig      <= 1'b0;
         pulse_idx <= '0;
         tx_h      <= 1'b0;
         tx_v      <= 1'b0;
         wave_sel  <= 2'd0;
         idx_q     <= '0;
         slot_q    <= 2'd0;
         ptr_q     <= '0;
      end else begin
         trig <= go;
         if (!run) begin
            idx_q  <= '0;
            slot_q <= 2'd0;
            ptr_q  <= '0;
         end else if (go) begin
            pulse_idx <= idx_q;
            idx_q     <= idx_q + 1'b1;
            tx_h      <= slot_code[0];
            tx_v      <= slot_code[1];
            wave_sel  <= wave_cfg_q;
            slot_q    <= (slot_q == pol_last_q) ? 2'd0 : slot_q + 1'b1;
            ptr_q     <= (ptr_q == ph_last_q) ? '0 : ptr_q + 1'b1;
         end
      end
   end

   // phase tables, one per channel
   logic [PHASE_W-1:0] phase_q [NCH];

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         logic tab_we;
         assign tab_we = cfg_we &&
                         (cfg_addr[CFG_AW-1 -: 2] == ((ch == 0) ? PAGE_TAB_H : PAGE_TAB_V));
         dps_phase_table #(
            .PHASE_W (PHASE_W),
            .DEPTH   (PH_DEPTH)
         ) i_tab (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tab_we),
            .waddr (cfg_addr[PH_AW-1:0]),
            .wdata (cfg_wdata[PHASE_W-1:0]),
            .rd_en (go),
            .raddr (ptr_q),
            .phase (phase_q[ch])
         );
      end
   endgenerate

   assign phase_h = phase_q[0];
   assign phase_v = phase_q[1];

   dps_envelope #(
      .ENV_W (ENV_W)
   ) i_env (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .start     (go),
      .width     (env_len_q),
      .shaped    (shaped_q),
      .env_addr  (env_addr),
      .env_valid (env_valid)
   );

   // checker state for the pulse number
   logic             chk_seen_q;
   logic [IDX_W-1:0] chk_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_seen_q <= 1'b0;
         chk_last_q <= '0;
      end else if (!run) begin
         chk_seen_q <= 1'b0;
      end else if (trig) begin
         chk_seen_q <= 1'b1;
         chk_last_q <= pulse_idx;
      end
   end

   // R1
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig && chk_seen_q |-> pulse_idx == chk_last_q + 1'b1);

   // R2
   trig_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);

   // R2
   prt_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (prt_a_q >= 2) && (prt_b_q >= 2));

   // R1
   first_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |=> trig);

endmodule

// File: tb/test_dual_pol_pulse_seq.sv
module test_dual_pol_pulse_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        trig;
   logic [15:0] pulse_idx;
   logic        tx_h, tx_v;
   logic [11:0] phase_h, phase_v;
   logic [1:0]  wave_sel;
   logic [7:0]  env_addr;
   logic        env_valid;

   always #2.5 clk = ~clk;

   dual_pol_pulse_seq i_dual_pol_pulse_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .trig      (trig),
      .pulse_idx (pulse_idx),
      .tx_h      (tx_h),
      .tx_v      (tx_v),
      .phase_h   (phase_h),
      .phase_v   (phase_v),
      .wave_sel  (wave_sel),
      .env_addr  (env_addr),
      .env_valid (env_valid)
   );

   localparam int PAT = 8'b00_11_01_10;
   localparam int LOGN = 128;

   int total = 0;
   int fails = 0;
   int cyc = 0;

   int ntrig, seen, since, stab_err, env_err, env_on, env_w, env_g;
   int last_h, last_v;
   int tlog [LOGN];
   int ilog [LOGN];
   int hlog [LOGN];
   int vlog [LOGN];
   int phlog [LOGN];
   int pvlog [LOGN];
   int wlog [LOGN];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int tab_h(int i);
      return (i * 293 + 11) & 12'hFFF;
   endfunction

   function automatic int tab_v(int i);
      return (i * 157 + 2048) & 12'hFFF;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor, samples on the falling edge
   always @(negedge clk) begin
      if (trig) begin
         if (ntrig < LOGN) begin
            tlog[ntrig]  = cyc;
            ilog[ntrig]  = pulse_idx;
            hlog[ntrig]  = tx_h;
            vlog[ntrig]  = tx_v;
            phlog[ntrig] = phase_h;
            pvlog[ntrig] = phase_v;
            wlog[ntrig]  = wave_sel;
         end
         ntrig++;
         since = 0;
         seen = 1;
         last_h = phase_h;
         last_v = phase_v;
      end else if (seen != 0) begin
         since++;
         if (phase_h != last_h || phase_v != last_v) stab_err++;
      end
      if (env_on != 0) begin
         bit ev;
         int ea;
         ev = (seen != 0) && (since < env_w);
         ea = (ev && env_g != 0) ? since : 0;
         if (env_valid !== ev || (ev && env_addr != ea)) env_err++;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      cfg_addr  = 8'(a);
      cfg_wdata = 16'(d);
      cfg_we    = 1'b1;
      tick();
      cfg_we    = 1'b0;
   endtask

   task automatic scen(input int md, input int a, input int b, input int l,
                       input int pl, input int phl, input int g, input int wv, input int n);
      int w, start;
      w = ((a < b) ? a : b) - 1;
      wr(8'h00, a);
      wr(8'h01, b);
      wr(8'h02, (wv << 3) | (g << 2) | md);
      wr(8'h03, l);
      wr(8'h04, (pl << 8) | PAT);
      wr(8'h05, phl);
      wr(8'h06, w);
      ntrig = 0; seen = 0; since = 0; stab_err = 0; env_err = 0;
      env_w = w; env_g = g; env_on = 1;
      start = cyc;
      run = 1'b1;
      while (ntrig < n) tick();
      env_on = 0;
      run = 1'b0;
      tick();
      tick();
      // R1: first trigger one cycle after run
      chk(tlog[0] - start == 1, "R1", "first trigger delay", tlog[0] - start, 1);
      for (int k = 0; k < n; k++) begin
         int code, ep;
         chk(ilog[k] == k, "R1", "pulse index", ilog[k], k);
         code = (PAT >> (2 * (k % (pl + 1)))) & 3;
         // R6: slot bit 0 is H, bit 1 is V
         chk(hlog[k] == (code & 1), "R6", "tx_h", hlog[k], code & 1);
         chk(vlog[k] == (code >> 1), "R6", "tx_v", vlog[k], code >> 1);
         // R7: independent tables
         chk(phlog[k] == tab_h(k % (phl + 1)), "R7", "phase_h", phlog[k], tab_h(k % (phl + 1)));
         chk(pvlog[k] == tab_v(k % (phl + 1)), "R7", "phase_v", pvlog[k], tab_v(k % (phl + 1)));
         // R10
         chk(wlog[k] == wv, "R10", "wave_sel", wlog[k], wv);
         if (k + 1 < n) begin
            if (md == 1) begin
               ep = (k % 2 != 0) ? b : a;
               chk(tlog[k+1] - tlog[k] == ep, "R3", "alternating gap", tlog[k+1] - tlog[k], ep);
            end else if (md == 2) begin
               ep = (((k / l) % 2) != 0) ? b : a;
               chk(tlog[k+1] - tlog[k] == ep, "R4", "run-mode gap", tlog[k+1] - tlog[k], ep);
            end else begin
               chk(tlog[k+1] - tlog[k] == a, "R2", "uniform gap", tlog[k+1] - tlog[k], a);
            end
         end
      end
      chk(stab_err == 0, "R8", "phase changes between triggers", stab_err, 0);
      chk(env_err == 0, "R9", "envelope mismatches", env_err, 0);
   endtask

   initial begin
      ntrig = 0; seen = 0; since = 0; env_on = 0; stab_err = 0; env_err = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: idle state after reset
      chk(trig == 1'b0, "R1", "reset trig", trig, 0);
      chk(pulse_idx == 0, "R1", "reset pulse_idx", pulse_idx, 0);
      chk(env_valid == 1'b0, "R9", "reset env_valid", env_valid, 0);
      chk(phase_h == 0 && phase_v == 0, "R7", "reset phase", phase_h, 0);
      chk(tx_h == 1'b0 && tx_v == 1'b0, "R6", "reset polarization", {tx_v, tx_h}, 0);

      for (int i = 0; i < 64; i++) begin
         wr(8'h40 + i, tab_h(i));
         wr(8'h80 + i, tab_v(i));
      end

      begin
         int sc = 0;
         int pa [3] = '{2, 4, 5};
         int pb [3] = '{3, 2, 7};
         int phs [4] = '{0, 5, 63, 17};
         for (int md = 0; md < 3; md++) begin
            for (int p = 0; p < 3; p++) begin
               for (int l = 1; l <= ((md == 2) ? 3 : 1); l++) begin
                  scen(md, pa[p], pb[p], l, sc % 4, phs[sc % 4], sc % 2, sc % 4, 70);
                  sc++;
               end
            end
         end
      end

      // R5: interval change mid-burst
      begin
         wr(8'h00, 6);
         wr(8'h01, 6);
         wr(8'h02, 0);
         ntrig = 0; seen = 0;
         run = 1'b1;
         while (ntrig < 2) tick();
         wr(8'h00, 9);
         while (ntrig < 4) tick();
         run = 1'b0;
         tick();
         chk(tlog[2] - tlog[1] == 6, "R5", "interval in progress", tlog[2] - tlog[1], 6);
         chk(tlog[3] - tlog[2] == 9, "R5", "interval after change", tlog[3] - tlog[2], 9);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(150000 * 5);
      total++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule